// File: doc/BRIEF.md
# USB Device Command Register File

This block holds the configuration state of a full-speed USB peripheral as seen by a local microcontroller. The microcontroller talks to it over a byte-wide command port: a command phase presents an 8-bit code, and a single data byte then either writes the selected register or is read from it. The block holds sixteen endpoint configuration bytes and one device address byte. Endpoint index 0 is control OUT, index 1 is control IN, and indices 2 to 15 are endpoints 1 to 14.

The device address has two copies. One is the readable register that the microcontroller writes. The other is the active address and enable that the USB side uses. A written address waits as pending until the host acknowledges the zero-length status packet on control IN. Only then is it copied to the active copy. A USB bus reset forces the active address to zero and enables the device, and the readable register keeps its value.

Any endpoint write that changes an enable bit or a size field raises a one-cycle invalidate pulse, because the buffer memory of every endpoint is then no longer valid. The size field is passed out raw.

Top module: `usb_cmd_regfile`

## Requirements
- R1: Command 0x20+i followed by a data write stores the byte in endpoint register i (i = 0..15). Command 0x30+i makes `rd_data` return that register, and `ep_cfg_flat[8*i +: 8]` shows it.
- R2: The endpoint byte layout is bit 7 buffer enable, bit 6 direction (1 = IN), bit 5 double buffer, bit 4 isochronous, and bits 3:0 size select. Every register resets to 0x00.
- R3: An endpoint write whose new byte differs from the old one in bit 7 or in bits 3:0 drives `fifo_invalidate` high for exactly the one cycle after the write edge.
- R4: An endpoint write that changes only bits 6:4, or that writes the same value again, leaves `fifo_invalidate` low.
- R5: Command 0xB6 with a data write stores the address register, and command 0xB7 reads it (bit 7 enable, bits 6:0 address). After reset the register reads 0x00 and the active address and enable are 0.
- R6: A written address is held as pending. The active address and enable stay unchanged until `status_ack` is pulsed, and they take the pending value on that edge.
- R7: A second address write made before the acknowledgement replaces the pending value.
- R8: On `bus_reset` the active address becomes 0 and the active enable becomes 1. The readable address register keeps its value, and any pending address is discarded, so a later `status_ack` changes nothing.
- R9: A command code outside the supported set makes `rd_data` return 0x00, and a data write after it changes no register.
- R10: A data write uses up the held write command. A second data write without a new command phase changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command phase strobe |
| cmd_code | input | 8 | Command code |
| wr_valid | input | 1 | Data phase write strobe |
| wr_data | input | 8 | Data byte to write |
| rd_data | output | 8 | Read value of the held command |
| bus_reset | input | 1 | USB bus reset event |
| status_ack | input | 1 | Host acknowledged the empty IN status packet |
| ep_cfg_flat | output | 128 | All endpoint configuration bytes, index i at bits 8i+7:8i |
| act_addr | output | 7 | Active device address |
| act_en | output | 1 | Active device enable |
| fifo_invalidate | output | 1 | One-cycle pulse: all endpoint buffer contents are invalid |

## Verification
The assertions check on every cycle that the invalidate pulse follows only an endpoint write that changed an enable or size field, and that every such write produces it. They also check that the active address moves only on an acknowledgement or a bus reset, and that a bus reset leaves the readable register alone. The bench scenarios show what no single-cycle property can: the read-back of all sixteen endpoints through the command port, the replacement of a pending address, a pending value dropped across a bus reset, and unsupported codes being ignored.

// File: rtl/usb_regfile_pkg.sv
package usb_regfile_pkg;
  localparam int CODE_W   = 8;
  localparam int IDX_W    = 4;
  localparam int NUM_EP   = 1 << IDX_W;
  localparam logic [3:0] EP_WR_GRP = 4'h2;
  localparam logic [3:0] EP_RD_GRP = 4'h3;
  localparam logic [7:0] ADDR_WR_CODE = 8'hB6;
  localparam logic [7:0] ADDR_RD_CODE = 8'hB7;

  typedef enum logic [2:0] {
    OP_NONE, OP_EP_WR, OP_EP_RD, OP_ADDR_WR, OP_ADDR_RD
  } op_e;

  function automatic op_e decode_op(input logic [7:0] code);
    if (code[7:4] == EP_WR_GRP)   return OP_EP_WR;
    if (code[7:4] == EP_RD_GRP)   return OP_EP_RD;
    if (code == ADDR_WR_CODE)     return OP_ADDR_WR;
    if (code == ADDR_RD_CODE)     return OP_ADDR_RD;
    return OP_NONE;
  endfunction

  // bit 7 enable and bits 3:0 size decide the buffer allocation
  function automatic logic alloc_changed(input logic [7:0] old_v, input logic [7:0] new_v);
    return (old_v[7] != new_v[7]) || (old_v[3:0] != new_v[3:0]);
  endfunction
endpackage

// File: rtl/usb_cmd_decoder.sv
module usb_cmd_decoder
  import usb_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              wr_valid,
  output op_e               held_op,
  output logic [IDX_W-1:0]  held_idx,
  output logic              ep_wr_stb,
  output logic              addr_wr_stb
);
  op_e              op_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_NONE;
      idx_q <= '0;
    end else if (cmd_valid) begin
      op_q  <= decode_op(cmd_code);
      idx_q <= cmd_code[IDX_W-1:0];
    end else if (wr_valid && (op_q == OP_EP_WR || op_q == OP_ADDR_WR)) begin
      op_q  <= OP_NONE;
    end
  end

  assign held_op     = op_q;
  assign held_idx    = idx_q;
  assign ep_wr_stb   = wr_valid && !cmd_valid && (op_q == OP_EP_WR);
  assign addr_wr_stb = wr_valid && !cmd_valid && (op_q == OP_ADDR_WR);

  assert_write_consumed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_wr_stb || addr_wr_stb) |=> !(ep_wr_stb || addr_wr_stb) || $past(cmd_valid) || $rose(cmd_valid));
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ep_wr_stb && addr_wr_stb));
endmodule

// File: rtl/usb_ep_cfg_bank.sv
module usb_ep_cfg_bank
  import usb_regfile_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_val,
  output logic [NUM_EP*8-1:0]     cfg_flat,
  output logic                    invalidate
);
  logic [7:0] cfg_q [NUM_EP];
  logic       alloc_hit;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    always_ff @(posedge clk) begin
      if (!rst_n)                                       cfg_q[i] <= 8'h00;
      else if (wr_stb && wr_idx == IDX_W'(i))           cfg_q[i] <= wr_data;
    end
    assign cfg_flat[8*i +: 8] = cfg_q[i];
  end

  assign alloc_hit = wr_stb && alloc_changed(cfg_q[wr_idx], wr_data);
  assign rd_val    = cfg_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) invalidate <= 1'b0;
    else        invalidate <= alloc_hit;
  end

  assert_inval_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |-> $past(wr_stb));
  assert_inval_follows_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_hit |=> invalidate);
  assert_no_inval_other_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !alloc_hit) |=> !invalidate);
  assert_inval_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidate && !$past(wr_stb, 1) ) |-> 1'b0);
endmodule

// File: rtl/usb_addr_ctrl.sv
module usb_addr_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       bus_reset,
  input  logic       status_ack,
  output logic [7:0] addr_reg,
  output logic [6:0] act_addr,
  output logic       act_en
);
  logic [7:0] pend_val;
  logic       pend_q;
  logic       commit;

  assign commit = status_ack && pend_q && !bus_reset;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_reg <= 8'h00;
    else if (wr_stb) addr_reg <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_val <= 8'h00;
    end else if (bus_reset) begin
      pend_q   <= 1'b0;
    end else if (wr_stb) begin
      pend_q   <= 1'b1;
      pend_val <= wr_data;
    end else if (commit) begin
      pend_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_addr <= 7'h00;
      act_en   <= 1'b0;
    end else if (bus_reset) begin
      act_addr <= 7'h00;
      act_en   <= 1'b1;
    end else if (commit) begin
      act_addr <= pend_val[6:0];
      act_en   <= pend_val[7];
    end
  end

  assert_active_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_ack && !bus_reset) |=> $stable(act_addr) && $stable(act_en));
  assert_bus_reset_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (act_addr == 7'h00) && act_en);
  assert_bus_reset_keeps_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !wr_stb) |=> $stable(addr_reg));
  assert_commit_takes_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_q || $past(wr_stb));
endmodule

// File: rtl/usb_cmd_regfile.sv
module usb_cmd_regfile
  import usb_regfile_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_code,
  input  logic                 wr_valid,
  input  logic [7:0]           wr_data,
  output logic [7:0]           rd_data,
  input  logic                 bus_reset,
  input  logic                 status_ack,
  output logic [16*8-1:0]      ep_cfg_flat,
  output logic [6:0]           act_addr,
  output logic                 act_en,
  output logic                 fifo_invalidate
);
  op_e              held_op;
  logic [IDX_W-1:0] held_idx;
  logic             ep_wr_stb, addr_wr_stb;
  logic [7:0]       ep_rd_val, addr_reg;

  usb_cmd_decoder u_dec (
    .clk, .rst_n, .cmd_valid, .cmd_code, .wr_valid,
    .held_op, .held_idx, .ep_wr_stb, .addr_wr_stb
  );

  usb_ep_cfg_bank u_bank (
    .clk, .rst_n, .wr_stb(ep_wr_stb), .wr_idx(held_idx), .wr_data,
    .rd_idx(held_idx), .rd_val(ep_rd_val), .cfg_flat(ep_cfg_flat),
    .invalidate(fifo_invalidate)
  );

  usb_addr_ctrl u_addr (
    .clk, .rst_n, .wr_stb(addr_wr_stb), .wr_data, .bus_reset, .status_ack,
    .addr_reg, .act_addr, .act_en
  );

  always_comb begin
    case (held_op)
      OP_EP_RD:   rd_data = ep_rd_val;
      OP_ADDR_RD: rd_data = addr_reg;
      default:    rd_data = 8'h00;
    endcase
  end

  assert_unsupported_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held_op == OP_NONE) |-> rd_data == 8'h00);
endmodule

// File: tb/usb_cmd_regfile_bench.sv
module usb_cmd_regfile_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, wr_valid = 0, bus_reset = 0, status_ack = 0;
  logic [7:0] cmd_code = 0, wr_data = 0, rd_data;
  logic [127:0] ep_cfg_flat;
  logic [6:0] act_addr;
  logic act_en, fifo_invalidate;
  int errors = 0, checks = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_cmd_regfile u_usb_cmd_regfile (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    @(negedge clk) cmd_valid = 1; cmd_code = c;
    @(negedge clk) cmd_valid = 0;
  endtask

  task automatic wdata(input logic [7:0] d);
    @(negedge clk) wr_valid = 1; wr_data = d;
    @(negedge clk) wr_valid = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) status_ack = 1;
    @(negedge clk) status_ack = 0;
  endtask

  task automatic pulse_bus_reset();
    @(negedge clk) bus_reset = 1;
    @(negedge clk) bus_reset = 0;
  endtask

  task automatic t_reset();
    cmd(8'h35); check("R2 reset ep", rd_data, 8'h00);
    check("R2 reset flat", ep_cfg_flat == '0, 1);
    cmd(8'hB7); check("R5 reset addr reg", rd_data, 8'h00);
    check("R5 reset active", {act_en, act_addr}, 8'h00);
  endtask

  task automatic t_ep_all();
    for (int i = 0; i < 16; i++) begin
      model[i] = 8'(i * 8'h13) ^ 8'h5A;
      cmd(8'h20 + 8'(i)); wdata(model[i]);
    end
    for (int i = 0; i < 16; i++) begin
      cmd(8'h30 + 8'(i));
      check($sformatf("R1 readback ep%0d", i), rd_data, model[i]);
      check($sformatf("R1 flat ep%0d", i), ep_cfg_flat[8*i +: 8], model[i]);
    end
  endtask

  task automatic t_invalidate();
    // R3: change enable bit of endpoint 3 (index 4)
    cmd(8'h24); wdata(model[4] ^ 8'h80); model[4] ^= 8'h80;
    check("R3 pulse on enable change", fifo_invalidate, 1);
    @(negedge clk); check("R3 pulse one cycle", fifo_invalidate, 0);
    cmd(8'h2F); wdata(model[15] ^ 8'h03); model[15] ^= 8'h03;
    check("R3 pulse on size change", fifo_invalidate, 1);
    // R4: direction, double buffer, iso only
    cmd(8'h22); wdata(model[2] ^ 8'h70); model[2] ^= 8'h70;
    check("R4 no pulse on bits 6:4", fifo_invalidate, 0);
    cmd(8'h22); wdata(model[2]);
    check("R4 no pulse on same value", fifo_invalidate, 0);
    cmd(8'h32); check("R2 bits 6:4 stored", rd_data, model[2]);
  endtask

  task automatic t_address();
    cmd(8'hB6); wdata(8'h85);
    cmd(8'hB7); check("R5 addr readback", rd_data, 8'h85);
    check("R6 active unchanged before ack", {act_en, act_addr}, 8'h00);
    cmd(8'hB6); wdata(8'h9C);
    check("R7 still unchanged", {act_en, act_addr}, 8'h00);
    pulse_ack();
    check("R7 replaced pending committed", {act_en, act_addr}, 8'h9C);
    pulse_ack();
    check("R6 ack without pending", {act_en, act_addr}, 8'h9C);
  endtask

  task automatic t_bus_reset();
    cmd(8'hB6); wdata(8'h0B);
    pulse_bus_reset();
    check("R8 active zero enabled", {act_en, act_addr}, 8'h80);
    cmd(8'hB7); check("R8 reg preserved", rd_data, 8'h0B);
    pulse_ack();
    check("R8 pending discarded", {act_en, act_addr}, 8'h80);
  endtask

  task automatic t_unsupported();
    logic [127:0] snap;
    snap = ep_cfg_flat;
    cmd(8'h41); check("R9 read unsupported", rd_data, 8'h00);
    wdata(8'hFF);
    check("R9 write ignored", ep_cfg_flat == snap, 1);
    cmd(8'hB7); check("R9 addr untouched", rd_data, 8'h0B);
    // R10: second data write without command
    cmd(8'h27); wdata(8'h11); model[7] = 8'h11;
    wdata(8'hEE);
    cmd(8'h37); check("R10 second write ignored", rd_data, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ep_all();
    t_invalidate();
    t_address();
    t_bus_reset();
    t_unsupported();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule